// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Registers

This block drives 32 general-purpose pins from a small synchronous register bus. The pins form two banks of sixteen. Each bank has three writable feature registers: pin output value, pin drive enable and input enable. Each bank also has one read-only register that returns the sampled input levels. The upper bank's registers sit 0x80 above the lower bank's.

A writable feature register is never overwritten as a whole. In each 32-bit write, the lower half carries a set mask for the bank's sixteen pins and the upper half carries a clear mask. Pins whose two mask bits are both zero keep their value. Software can therefore change one pin with a single write, and needs no read-modify-write and no lock. Pad inputs pass through a two-flop synchronizer before software can read them. Read data is registered and appears on the cycle after the read strobe.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every feature bit is 0, so `pad_oe` and `pad_out` are all zero and every register reads back 0.
- R2: A write to a feature register with bit n (n = 0..15) at 1 sets that feature for pin n of the bank. The lower bank is at offsets 0x00..0x0C and serves pins 0..15. The upper bank is at 0x80..0x8C and serves pins 16..31.
- R3: In the same write, bit n+16 at 1 clears that feature for pin n of the bank.
- R4: A pin whose set and clear bits are both 0 in a write keeps its value, and no output changes in a cycle without a write.
- R5: When a write has both the set bit and the clear bit of one pin at 1, the feature ends cleared.
- R6: Within a bank, pin output value is at offset 0x00, drive enable at 0x04 and input enable at 0x08. All three use the same set/clear encoding and change independently of each other.
- R7: A read strobe sampled at a clock edge puts the addressed register's sixteen pin bits on `bus_rdata[15:0]` with bits 31:16 at 0, valid from that edge until the next one. After an edge with no read strobe, `bus_rdata` is 0.
- R8: `pad_oe[i]` equals the drive-enable bit of pin i. `pad_out[i]` equals the output-value bit when drive enable is 1 and is 0 otherwise.
- R9: Offset 0x0C of each bank is read-only. It returns each pin's input after a two-flop synchronizer, and returns 0 for pins whose input enable is 0. A change on `pad_in` that is present at edge k can be seen by a read strobe sampled at edge k+2.
- R10: Writes to undefined offsets, and writes to offset 0x0C, change nothing. Reads from undefined offsets return 0. Defined offsets are 0x00, 0x04, 0x08 and 0x0C in each bank.
- R11: Back-to-back writes take effect in arrival order, one per clock. Each write's result is visible on the pads in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data: set mask in 15:0, clear mask in 31:16 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |

## Verification
Some rules hold on every cycle, and the assertions check them there. Drive gating of `pad_out` by `pad_oe` is one. Outputs stay stable without a write, and undefined writes change nothing. In the lower bank's drive-enable register, set bits land and clear bits win. The upper half of read data is zero, and read data returns to zero after an idle cycle.

Other behaviour only the bench's reference model can show, because it compares every output against the model on every clock. That covers the exact two-edge synchronizer latency and input masking. It also covers the upper bank's address offset and the ordering of consecutive writes to one register. Finally it covers a randomized mix of reads and writes to defined and undefined offsets.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Register offsets inside one bank (byte addresses)
    localparam int unsigned OFS_OUT_VAL = 32'h00;
    localparam int unsigned OFS_OUT_EN  = 32'h04;
    localparam int unsigned OFS_IN_EN   = 32'h08;
    localparam int unsigned OFS_IN_VAL  = 32'h0C;

    typedef enum logic [1:0] {
        FT_OUT_VAL = 2'd0,
        FT_OUT_EN  = 2'd1,
        FT_IN_EN   = 2'd2,
        FT_IN_VAL  = 2'd3
    } feat_e;

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pinbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BANK_SHIFT = 7,
    parameter int NUM_BANKS  = 2,
    localparam int BIDX_W    = ADDR_W - BANK_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BIDX_W-1:0] bank_idx,
    output feat_e             feat
);

    logic [BANK_SHIFT-1:0] local_ofs;
    logic                  bank_ok;

    always_comb begin
        local_ofs = addr[BANK_SHIFT-1:0];
        bank_idx  = addr[ADDR_W-1:BANK_SHIFT];
        bank_ok   = (32'(bank_idx) < 32'(NUM_BANKS));
        hit       = 1'b0;
        feat      = FT_OUT_VAL;
        if (local_ofs == BANK_SHIFT'(OFS_OUT_VAL)) begin
            hit  = bank_ok;
            feat = FT_OUT_VAL;
        end else if (local_ofs == BANK_SHIFT'(OFS_OUT_EN)) begin
            hit  = bank_ok;
            feat = FT_OUT_EN;
        end else if (local_ofs == BANK_SHIFT'(OFS_IN_EN)) begin
            hit  = bank_ok;
            feat = FT_IN_EN;
        end else if (local_ofs == BANK_SHIFT'(OFS_IN_VAL)) begin
            hit  = bank_ok;
            feat = FT_IN_VAL;
        end
    end

endmodule

// File: rtl/pb_sync2.sv
module pb_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;

endmodule

// File: rtl/pb_bank.sv
module pb_bank
    import pinbank_pkg::*;
#(
    parameter int LINES  = 16,
    localparam int DW    = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  feat_e            wr_feat,
    input  logic [DW-1:0]    wdata,
    input  logic [LINES-1:0] sync_in,
    output logic [LINES-1:0] out_val,
    output logic [LINES-1:0] out_en,
    output logic [LINES-1:0] in_en,
    output logic [LINES-1:0] in_val
);

    typedef struct packed {
        logic [LINES-1:0] ov;
        logic [LINES-1:0] oe;
        logic [LINES-1:0] ie;
    } bank_t;

    bank_t bank_d, bank_q;

    // Set mask in the lower half, clear mask in the upper half; clear wins.
    function automatic logic [LINES-1:0] merge(input logic [LINES-1:0] cur,
                                               input logic [DW-1:0]    w);
        return (cur | w[LINES-1:0]) & ~w[DW-1:LINES];
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_go) begin
            unique case (wr_feat)
                FT_OUT_VAL: bank_d.ov = merge(bank_q.ov, wdata);
                FT_OUT_EN:  bank_d.oe = merge(bank_q.oe, wdata);
                FT_IN_EN:   bank_d.ie = merge(bank_q.ie, wdata);
                default:    bank_d    = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign out_val = bank_q.ov;
    assign out_en  = bank_q.oe;
    assign in_en   = bank_q.ie;
    assign in_val  = sync_in & bank_q.ie;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int LINES_PER_BANK = 16,
    parameter int NUM_BANKS      = 2,
    parameter int BANK_SHIFT     = 7,
    localparam int NUM_LINES     = NUM_BANKS * LINES_PER_BANK,
    localparam int DW            = 2 * LINES_PER_BANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe
);

    localparam int BIDX_W = ADDR_W - BANK_SHIFT;
    localparam int L      = LINES_PER_BANK;

    logic              dec_hit;
    logic [BIDX_W-1:0] dec_idx;
    feat_e             dec_feat;
    logic              wr_ok;

    logic [NUM_LINES-1:0] pad_sync;

    logic [NUM_BANKS-1:0][L-1:0] bk_ov;
    logic [NUM_BANKS-1:0][L-1:0] bk_oe;
    logic [NUM_BANKS-1:0][L-1:0] bk_ie;
    logic [NUM_BANKS-1:0][L-1:0] bk_iv;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_t;

    top_t top_d, top_q;

    pb_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_SHIFT (BANK_SHIFT),
        .NUM_BANKS  (NUM_BANKS)
    ) u_decode (
        .addr     (bus_addr),
        .hit      (dec_hit),
        .bank_idx (dec_idx),
        .feat     (dec_feat)
    );

    pb_sync2 #(
        .W (NUM_LINES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    assign wr_ok = bus_wr && dec_hit && (dec_feat != FT_IN_VAL);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_go;
        assign bank_go = wr_ok && (32'(dec_idx) == b);

        pb_bank #(
            .LINES (L)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_go   (bank_go),
            .wr_feat (dec_feat),
            .wdata   (bus_wdata),
            .sync_in (pad_sync[b*L +: L]),
            .out_val (bk_ov[b]),
            .out_en  (bk_oe[b]),
            .in_en   (bk_ie[b]),
            .in_val  (bk_iv[b])
        );

        assign pad_oe[b*L +: L]  = bk_oe[b];
        assign pad_out[b*L +: L] = bk_ov[b] & bk_oe[b];
    end

    always_comb begin
        top_d.rdata = '0;
        if (bus_rd && dec_hit) begin
            unique case (dec_feat)
                FT_OUT_VAL: top_d.rdata = {{L{1'b0}}, bk_ov[dec_idx]};
                FT_OUT_EN:  top_d.rdata = {{L{1'b0}}, bk_oe[dec_idx]};
                FT_IN_EN:   top_d.rdata = {{L{1'b0}}, bk_ie[dec_idx]};
                FT_IN_VAL:  top_d.rdata = {{L{1'b0}}, bk_iv[dec_idx]};
                default:    top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;

endmodule

// File: rtl/pb_checker.sv
module pb_checker
    import pinbank_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int LINES_PER_BANK = 16,
    parameter int NUM_BANKS      = 2,
    parameter int BANK_SHIFT     = 7,
    localparam int NUM_LINES     = NUM_BANKS * LINES_PER_BANK,
    localparam int DW            = 2 * LINES_PER_BANK,
    localparam int L             = LINES_PER_BANK
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [DW-1:0]        bus_rdata,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe
);

    logic [BANK_SHIFT-1:0] ofs;
    logic                  bank_valid;
    logic                  wr_undef;
    logic                  wr_oe_low;

    assign ofs        = bus_addr[BANK_SHIFT-1:0];
    assign bank_valid = (32'(bus_addr[ADDR_W-1:BANK_SHIFT]) < 32'(NUM_BANKS));
    assign wr_undef   = bus_wr && !(bank_valid &&
                        (ofs == BANK_SHIFT'(OFS_OUT_VAL) ||
                         ofs == BANK_SHIFT'(OFS_OUT_EN)  ||
                         ofs == BANK_SHIFT'(OFS_IN_EN)));
    assign wr_oe_low  = bus_wr && (bus_addr == ADDR_W'(OFS_OUT_EN));

    assert_drive_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_oe) && $stable(pad_out)));

    assert_rd_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_rd_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[DW-1:L] == '0));

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe_low |=> ((($past(bus_wdata[L-1:0]) & ~$past(bus_wdata[DW-1:L]))
                        & ~pad_oe[L-1:0]) == '0));

    // covers R3 as well: every clear bit leaves the pin disabled
    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe_low |=> ((pad_oe[L-1:0] & $past(bus_wdata[DW-1:L])) == '0));

    assert_undef_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_undef |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind pinbank_ctrl pb_checker #(
    .ADDR_W         (ADDR_W),
    .LINES_PER_BANK (LINES_PER_BANK),
    .NUM_BANKS      (NUM_BANKS),
    .BANK_SHIFT     (BANK_SHIFT)
) u_pb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pinbank_ctrl i_pinbank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Behavioural reference model, one 32-bit word per feature
    logic [31:0] m_ov, m_oe, m_ie, m_s1, m_s2, m_rd;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int bank = a >> 7;
        int ofs  = a & 8'h7F;
        logic [31:0] r = '0;
        if (bank < 2) begin
            case (ofs)
                'h00: r = (m_ov >> (16*bank)) & 32'hFFFF;
                'h04: r = (m_oe >> (16*bank)) & 32'hFFFF;
                'h08: r = (m_ie >> (16*bank)) & 32'hFFFF;
                'h0C: r = ((m_s2 & m_ie) >> (16*bank)) & 32'hFFFF;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] upd(input logic [31:0] cur, input int bank,
                                        input logic [31:0] w);
        logic [31:0] setm = {16'h0, w[15:0]}  << (16*bank);
        logic [31:0] clrm = {16'h0, w[31:16]} << (16*bank);
        return (cur | setm) & ~clrm;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ov = '0; m_oe = '0; m_ie = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
        end else begin
            m_rd = bus_rd ? m_read(bus_addr) : 32'h0;
            if (bus_wr && (bus_addr >> 7) < 2) begin
                case (bus_addr & 8'h7F)
                    'h00: m_ov = upd(m_ov, bus_addr >> 7, bus_wdata);
                    'h04: m_oe = upd(m_oe, bus_addr >> 7, bus_wdata);
                    'h08: m_ie = upd(m_ie, bus_addr >> 7, bus_wdata);
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 pad_oe",    pad_oe,    m_oe);
            check("R8 pad_out",   pad_out,   m_ov & m_oe);
            check("R7 bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 pad_out reset", pad_out, 32'h0);
        rd_chk("R1 out_val reset", 8'h00, 32'h0);
        rd_chk("R1 out_en reset hi bank", 8'h84, 32'h0);
        rd_chk("R1 in_en reset", 8'h08, 32'h0);

        // R2: set bits in drive enable, low bank
        wr(8'h04, 32'h0000_0005);
        check("R2 set oe lines 0,2", pad_oe, 32'h0000_0005);
        rd_chk("R7 readback oe", 8'h04, 32'h0000_0005);

        // R8: value only appears where driven
        wr(8'h00, 32'h0000_0003);
        check("R8 gated out", pad_out, 32'h0000_0001);

        // R3 and R4: clear line 0, set line 2, line 1 untouched
        wr(8'h00, 32'h0001_0004);
        rd_chk("R3 R4 out_val", 8'h00, 32'h0000_0006);

        // R2: upper bank at 0x80
        wr(8'h84, 32'h0000_8001);
        check("R2 hi bank oe", pad_oe, 32'h8001_0005);

        // R5: both bits for line 16 -> cleared
        wr(8'h84, 32'h0001_0001);
        check("R5 clear wins", pad_oe, 32'h8000_0005);

        // R6: in_en independent of the other registers
        wr(8'h08, 32'h0000_00FF);
        rd_chk("R6 in_en", 8'h08, 32'h0000_00FF);
        rd_chk("R6 oe untouched", 8'h04, 32'h0000_0005);

        // R10: writes to undefined offsets and to input value ignored
        wr(8'h10, 32'h0000_FFFF);
        wr(8'h0C, 32'h0000_FFFF);
        wr(8'h90, 32'h0000_FFFF);
        check("R10 oe unchanged", pad_oe, 32'h8000_0005);
        rd_chk("R10 undefined read", 8'h10, 32'h0);
        rd_chk("R10 out_val unchanged", 8'h00, 32'h0000_0006);

        // R9: synchronized and masked input
        @(negedge clk);
        pad_in = 32'hA5A5_A5A5;
        repeat (3) @(negedge clk);
        rd_chk("R9 in_val low", 8'h0C, 32'h0000_00A5);
        rd_chk("R9 in_val hi disabled", 8'h8C, 32'h0);
        // latency: change then read at once; model checks the two-edge delay
        @(negedge clk);
        pad_in = 32'h0000_005A;
        bus_addr = 8'h0C; bus_rd = 1'b1;
        @(negedge clk);
        check("R9 still old", bus_rdata, 32'h0000_00A5);
        @(negedge clk);
        check("R9 still old 2", bus_rdata, 32'h0000_00A5);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R9 new value", bus_rdata, 32'h0000_005A);

        // R11: back-to-back writes in order
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'h0000_0020; bus_wr = 1'b1;
        @(negedge clk);
        check("R11 first write", pad_oe, 32'h8000_0025);
        bus_wdata = 32'h0020_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11 second write", pad_oe, 32'h8000_0005);

        // Random mix, compared every cycle by the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            case ($urandom_range(0, 11))
                0: bus_addr = 8'h00;  1: bus_addr = 8'h04;
                2: bus_addr = 8'h08;  3: bus_addr = 8'h0C;
                4: bus_addr = 8'h80;  5: bus_addr = 8'h84;
                6: bus_addr = 8'h88;  7: bus_addr = 8'h8C;
                8: bus_addr = 8'h10;  9: bus_addr = 8'h7C;
                10: bus_addr = 8'h94; default: bus_addr = 8'h02;
            endcase
            bus_wdata = $urandom;
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_rd    = ($urandom_range(0, 1) == 0);
            if ($urandom_range(0, 3) == 0) pad_in = $urandom;
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule